// File: doc/BRIEF.md
# Synchronous Dual-Enable Up/Down Counter Stage

This block is one stage of a synchronous counter. All of its state bits are clocked together from one clock, and no clock is derived from a counter bit. The stage counts up or down. It works either as a full binary counter (modulo 16 at the default width) or as a decade counter (modulo 10). In decade mode the wrap is taken on the clock edge, so no illegal code is ever decoded and then cleared afterwards.

Counting needs two enables to be high together. The first, `en_count`, gates this stage only. The second, `en_chain`, gates the stage and also qualifies the stage's terminal-count flag `carry_o`. Several stages can therefore be cascaded by driving every `en_count` from a shared enable and feeding each `carry_o` into the `en_chain` of the next stage. A count advances only when every lower stage sits at its terminal value.

Top module: `sync_cnt_stage`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, the count becomes 0 after that edge, whatever the enables, direction and mode are.
- R2: When `en_count` and `en_chain` are not both 1, the count keeps its value across the edge.
- R3: With `dir_up`=1 and `dec_mode`=0, each enabled edge adds one to the count, and 15 is followed by 0.
- R4: With `dir_up`=0 and `dec_mode`=0, each enabled edge subtracts one from the count, and 0 is followed by 15.
- R5: With `dir_up`=1 and `dec_mode`=1, counts 0 to 8 step up by one, and 9 is followed by 0. The value 10 is never reached from a legal count.
- R6: With `dir_up`=0 and `dec_mode`=1, counts 1 to 9 step down by one, and 0 is followed by 9.
- R7: With `dec_mode`=1, an enabled edge while the count is above 9 loads 0, in either direction.
- R8: `carry_o` is 1 exactly when `en_chain` is 1 and the count sits at the terminal value. When counting up the terminal value is 15 in binary mode and 9 in decade mode. When counting down it is 0.
- R9: `carry_o` does not depend on `en_count`.
- R10: In binary up counting, bit i changes on an enabled edge exactly when all bits below i are 1.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all state bits |
| rst | input | 1 | Synchronous reset, active high |
| en_count | input | 1 | Count enable local to this stage |
| en_chain | input | 1 | Count enable that also qualifies carry_o |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| dec_mode | input | 1 | 1 = decade (mod 10), 0 = binary (mod 16) |
| count_o | output | 4 | Current count |
| carry_o | output | 1 | Terminal-count flag for cascading |

## Verification
The bench builds the stage with its default parameters: a 4-bit width and a decade modulus of 10. The whole 16-value state space is therefore small enough for long random runs to visit every count in every mode and direction. Because `dec_mode` can be switched while the count is above 9, the random runs also reach the out-of-range decade codes 10 to 15. Directed runs cover every wrap point, an enable held low at the terminal count, and reset asserted while both enables are high.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    // Kind of update applied to the count on the next edge.
    typedef enum logic [2:0] {
        STEP_HOLD,
        STEP_INC,
        STEP_DEC,
        STEP_CLR,
        STEP_PRESET
    } step_kind_e;
endpackage

// File: rtl/cnt_toggle_mask.sv
// Toggle masks of a T flip-flop counter. In up counting a bit flips when
// every lower bit is 1; in down counting, when every lower bit is 0.
module cnt_toggle_mask #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] up_mask,
    output logic [WIDTH-1:0] dn_mask
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign up_mask[i] = 1'b1;
            assign dn_mask[i] = 1'b1;
        end else begin : g_upper
            assign up_mask[i] = &cur[i-1:0];
            assign dn_mask[i] = ~|cur[i-1:0];
        end
    end
endmodule

// File: rtl/cnt_terminal.sv
// Decodes the boundary values of the count for the current mode.
module cnt_terminal #(
    parameter int WIDTH   = 4,
    parameter int DEC_MOD = 10
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             dir_up,
    input  logic             dec_mode,
    output logic             at_dec_top,
    output logic             at_zero,
    output logic             dec_oor,
    output logic             terminal
);
    localparam logic [WIDTH-1:0] DEC_TOP = WIDTH'(DEC_MOD - 1);

    logic at_bin_top;

    always_comb begin
        at_bin_top = &cur;
        at_dec_top = (cur == DEC_TOP);
        at_zero    = ~|cur;
        dec_oor    = (cur > DEC_TOP);
        if (dir_up) begin
            terminal = dec_mode ? at_dec_top : at_bin_top;
        end else begin
            terminal = at_zero;
        end
    end
endmodule

// File: rtl/sync_cnt_stage.sv
module sync_cnt_stage
    import cnt_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter int DEC_MOD = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_count,
    input  logic             en_chain,
    input  logic             dir_up,
    input  logic             dec_mode,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_o
);
    localparam logic [WIDTH-1:0] DEC_TOP = WIDTH'(DEC_MOD - 1);

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } state_t;

    state_t     st_d, st_q;
    step_kind_e step_d;

    logic [WIDTH-1:0] up_mask, dn_mask;
    logic at_dec_top, at_zero, dec_oor, terminal;

    cnt_toggle_mask #(.WIDTH(WIDTH)) u_mask (
        .cur     (st_q.count),
        .up_mask (up_mask),
        .dn_mask (dn_mask)
    );

    cnt_terminal #(.WIDTH(WIDTH), .DEC_MOD(DEC_MOD)) u_term (
        .cur        (st_q.count),
        .dir_up     (dir_up),
        .dec_mode   (dec_mode),
        .at_dec_top (at_dec_top),
        .at_zero    (at_zero),
        .dec_oor    (dec_oor),
        .terminal   (terminal)
    );

    always_comb begin
        if (rst) begin
            step_d = STEP_CLR;
        end else if (!(en_count && en_chain)) begin
            step_d = STEP_HOLD;
        end else if (dec_mode && dec_oor) begin
            step_d = STEP_CLR;
        end else if (dir_up) begin
            step_d = (dec_mode && at_dec_top) ? STEP_CLR : STEP_INC;
        end else begin
            step_d = (dec_mode && at_zero) ? STEP_PRESET : STEP_DEC;
        end

        st_d = st_q;
        unique case (step_d)
            STEP_INC:    st_d.count = st_q.count ^ up_mask;
            STEP_DEC:    st_d.count = st_q.count ^ dn_mask;
            STEP_CLR:    st_d.count = '0;
            STEP_PRESET: st_d.count = DEC_TOP;
            default:     st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign carry_o = en_chain & terminal;
endmodule

// File: rtl/sync_cnt_stage_chk.sv
module sync_cnt_stage_chk #(
    parameter int WIDTH   = 4,
    parameter int DEC_MOD = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             en_count,
    input logic             en_chain,
    input logic             dir_up,
    input logic             dec_mode,
    input logic [WIDTH-1:0] count_o,
    input logic             carry_o
);
    localparam logic [WIDTH-1:0] TOP = WIDTH'(DEC_MOD - 1);

    logic go;
    assign go = en_count && en_chain;

    p_reset_r1: assert property (@(posedge clk) rst |=> count_o == '0);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !go |=> $stable(count_o));

    p_bin_up_r3: assert property (@(posedge clk) disable iff (rst)
        (go && dir_up && !dec_mode) |=> count_o == WIDTH'($past(count_o) + 1'b1));

    p_bin_dn_r4: assert property (@(posedge clk) disable iff (rst)
        (go && !dir_up && !dec_mode) |=> count_o == WIDTH'($past(count_o) - 1'b1));

    p_dec_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (go && dir_up && dec_mode && count_o == TOP) |=> count_o == '0);

    p_dec_under_r6: assert property (@(posedge clk) disable iff (rst)
        (go && !dir_up && dec_mode && count_o == '0) |=> count_o == TOP);

    p_dec_oor_r7: assert property (@(posedge clk) disable iff (rst)
        (go && dec_mode && count_o > TOP) |=> count_o == '0);

    p_carry_gate_r8: assert property (@(posedge clk) disable iff (rst)
        carry_o |-> en_chain);

    p_carry_down_r8: assert property (@(posedge clk) disable iff (rst)
        (en_chain && !dir_up) |-> carry_o == (count_o == '0));
endmodule

bind sync_cnt_stage sync_cnt_stage_chk #(.WIDTH(WIDTH), .DEC_MOD(DEC_MOD)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en_count (en_count),
    .en_chain (en_chain),
    .dir_up   (dir_up),
    .dec_mode (dec_mode),
    .count_o  (count_o),
    .carry_o  (carry_o)
);

// File: tb/sync_cnt_stage_tb.sv
module sync_cnt_stage_tb;
    logic clk = 1'b0;
    logic rst = 1'b1, en_count = 1'b0, en_chain = 1'b0, dir_up = 1'b1, dec_mode = 1'b0;
    logic [3:0] count_o;
    logic carry_o;

    int n_tests = 0;
    int n_fail = 0;
    int exp_cnt = 0;
    bit known = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sync_cnt_stage u_dut (
        .clk(clk), .rst(rst), .en_count(en_count), .en_chain(en_chain),
        .dir_up(dir_up), .dec_mode(dec_mode), .count_o(count_o), .carry_o(carry_o)
    );

    function automatic int ref_next(int q, bit r, bit ep, bit et, bit up, bit dec);
        if (r) return 0;
        if (!(ep && et)) return q;
        if (dec) begin
            if (q > 9) return 0;
            if (up) return (q == 9) ? 0 : q + 1;
            return (q == 0) ? 9 : q - 1;
        end
        return up ? (q + 1) % 16 : (q + 15) % 16;
    endfunction

    function automatic bit ref_carry(int q, bit et, bit up, bit dec);
        if (!et) return 0;
        if (up) return dec ? (q == 9) : (q == 15);
        return q == 0;
    endfunction

    function automatic string tag_of(int q, bit r, bit ep, bit et, bit up, bit dec);
        if (r) return "R1";
        if (!(ep && et)) return "R2";
        if (dec && q > 9) return "R7";
        if (dec) return up ? "R5" : "R6";
        return up ? "R3" : "R4";
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(bit r, bit ep, bit et, bit up, bit dec);
        int nx;
        @(negedge clk);
        rst = r; en_count = ep; en_chain = et; dir_up = up; dec_mode = dec;
        #1;
        if (known) check((!ep && et) ? "R9" : "R8", int'(carry_o), int'(ref_carry(exp_cnt, et, up, dec)));
        nx = ref_next(exp_cnt, r, ep, et, up, dec);
        @(posedge clk);
        #1;
        if (r || known) begin
            check(tag_of(exp_cnt, r, ep, et, up, dec), int'(count_o), nx);
            if (!r && ep && et && up && !dec) begin
                int mask = 1;
                for (int i = 1; i < 4; i++)
                    if (((exp_cnt >> 0) & ((1 << i) - 1)) == ((1 << i) - 1)) mask |= (1 << i);
                check("R10", int'(count_o) ^ exp_cnt, mask);
            end
        end
        exp_cnt = nx;
        known = 1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5eed;
        void'($urandom(seed));
        cyc(1, 1, 1, 1, 0);               // R1 reset with enables high
        cyc(1, 0, 0, 0, 1);
        for (int k = 0; k < 17; k++) cyc(0, 1, 1, 1, 0);  // R3 full binary lap, R10
        for (int k = 0; k < 17; k++) cyc(0, 1, 1, 0, 0);  // R4 down wrap
        cyc(1, 1, 1, 1, 1);
        for (int k = 0; k < 11; k++) cyc(0, 1, 1, 1, 1);  // R5 decade up wrap
        for (int k = 0; k < 11; k++) cyc(0, 1, 1, 0, 1);  // R6 decade down wrap
        cyc(1, 0, 0, 1, 0);
        for (int k = 0; k < 12; k++) cyc(0, 1, 1, 1, 0);  // reach 12
        cyc(0, 1, 1, 1, 1);                               // R7 up
        cyc(1, 0, 0, 1, 0);
        for (int k = 0; k < 14; k++) cyc(0, 1, 1, 1, 0);  // reach 14
        cyc(0, 1, 1, 0, 1);                               // R7 down
        cyc(1, 0, 0, 1, 0);
        for (int k = 0; k < 15; k++) cyc(0, 1, 1, 1, 0);  // reach 15
        cyc(0, 0, 1, 1, 0);                               // R9 carry with en_count low, R2 hold
        cyc(0, 1, 0, 1, 0);                               // R2 hold, R8 carry low
        for (int k = 0; k < 4000; k++) begin
            cyc(($urandom % 40) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
                $urandom % 2, ($urandom % 8) < 3);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule